// File: doc/BRIEF.md
# Reciprocal-Refinement Fixed-Point Divider

This block divides an unsigned 16-bit numerator by an unsigned 16-bit divisor and returns the quotient in 16.16 fixed point. It does not subtract one quotient bit per cycle. Instead it builds a reciprocal of the divisor and multiplies the numerator by it. The divisor is first normalized: a leading-zero count shifts it up until its top set bit lands in the most significant position of a 32-bit word. A reciprocal estimate then starts from a fixed seed and is sharpened by a fixed number of Newton refinements. The refined reciprocal multiplies the numerator, which has been shifted up by 16 places. A final right shift that depends on the leading-zero count undoes the normalization.

A single shared multiplier does all the work, one product per cycle. Each refinement takes two cycles and the final scaling takes one, so the latency is fixed and does not depend on the operands. A caller pulses `start` with the operands and waits for the one-cycle `done` pulse. The caller is responsible for keeping the operands in range: the divisor must be nonzero and the numerator must be below twice the divisor, so the quotient stays below 2.0. There is no division-by-zero detection.

Top module: `nr_recip_div`

## Requirements
- R1: When `start` is accepted while idle, `done` pulses high exactly 9 clock cycles later (two cycles per refinement with 4 refinements, plus one scaling cycle), whatever the operand values.
- R2: When den is nonzero and num < 2*den, `quo` at `done` lies within [E-3, E+1], where E = floor(num*65536/den); bits 31:16 carry the integer part and bits 15:0 the fraction.
- R3: The divisor is normalized so that its top set bit sits at bit 31 of the working word. Divisors whose top set bit is at any position 0 through 15 all meet the R2 accuracy.
- R4: `busy` is low while idle. It is high from the cycle after an accepted `start` until the cycle in which `done` is high, and it is low in that cycle.
- R5: A `start` pulse while `busy` is high is ignored. The running division finishes on its original schedule with its original operands, and no extra `done` follows.
- R6: `done` is high for exactly one cycle per accepted `start`.
- R7: `quo` holds its value from one `done` until the next `done`, including while a new division is running.
- R8: Reset (active low, asynchronous) returns the block to idle with `busy`, `done` and `quo` all zero. An interrupted division produces no `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division; sampled only while idle |
| num | input | 16 | Unsigned numerator |
| den | input | 16 | Unsigned divisor, nonzero, greater than num/2 |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when `quo` is updated |
| quo | output | 32 | Quotient in 16.16 fixed point |

## Verification
The bench builds the block with its defaults: 16-bit operands and four refinements. With these values the seed's worst starting error is reachable: a power-of-two divisor puts the normalized value at exactly one half. A sweep over all sixteen leading-zero positions exercises every normalization and denormalization shift. Ratios close to 2.0 and close to zero test the far ends of the final scaling shift. A restart attempt in the middle of a division and a reset during a division test the sequencing rules.

// File: rtl/nr_div_pkg.sv
package nr_div_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_EST,
      ST_REF,
      ST_SCL
   } nr_state_t;
endpackage

// File: rtl/nr_lzc.sv
// Leading-zero count of a W-bit word; an all-zero word yields zero.
module nr_lzc #(
   parameter int W  = 32,
   localparam int KW = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic [KW-1:0] zeros
);
   always_comb begin
      zeros = '0;
      for (int i = 0; i < W; i++) begin
         if (vec[i]) zeros = KW'(W - 1 - i);
      end
   end
endmodule

// File: rtl/nr_smul.sv
// Signed multiply of two (W+1)-bit operands, kept to the low 2W bits.
module nr_smul #(
   parameter int W = 32
) (
   input  logic signed [W:0]     a,
   input  logic signed [W:0]     b,
   output logic signed [2*W-1:0] p
);
   logic signed [2*W-1:0] a_x, b_x;

   assign a_x = {{(W-1){a[W]}}, a};
   assign b_x = {{(W-1){b[W]}}, b};
   assign p   = a_x * b_x;
endmodule

// File: rtl/nr_recip_div.sv
module nr_recip_div #(
   parameter int IN_W  = 16,
   parameter int ITERS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [IN_W-1:0]   num,
   input  logic [IN_W-1:0]   den,
   output logic              busy,
   output logic              done,
   output logic [2*IN_W-1:0] quo
);
   import nr_div_pkg::*;

   localparam int W   = 2 * IN_W;
   localparam int KW  = $clog2(W);
   localparam int IW  = $clog2(ITERS + 1);
   localparam int LAT = 2 * ITERS + 1;
   localparam int CW  = $clog2(LAT + 2);
   localparam logic [W-1:0] SEED = W'(77) << (W - 8);

   generate
      if (IN_W < 8 || IN_W > 16) begin : g_bad_width
         $error("nr_recip_div: IN_W must lie in 8..16");
      end
      if (ITERS < 3 || ITERS > 6) begin : g_bad_iters
         $error("nr_recip_div: ITERS must lie in 3..6");
      end
   endgenerate

   nr_state_t         state_q;
   logic [W-1:0]      dn_q, nsh_q, r_q, t_q, quo_q;
   logic [KW-1:0]     k_q, lz;
   logic [IW-1:0]     it_q;
   logic              done_q;
   logic [W-1:0]      den_ext, corr, hi_w;
   logic signed [W:0] op_a, op_b;
   logic signed [2*W-1:0] prod;
   logic [KW:0]       sh;

   assign den_ext = W'(den);

   nr_lzc #(.W(W)) u_lzc (
      .vec   (den_ext),
      .zeros (lz)
   );

   nr_smul #(.W(W)) u_mul (
      .a (op_a),
      .b (op_b),
      .p (prod)
   );

   // one shared product per cycle, operands picked by phase
   always_comb begin
      corr = '0 - (t_q << 2);
      op_a = '0;
      op_b = '0;
      case (state_q)
         ST_EST: begin
            op_a = {1'b0, dn_q};
            op_b = {1'b0, r_q};
         end
         ST_REF: begin
            op_a = {corr[W-1], corr};
            op_b = {1'b0, r_q};
         end
         ST_SCL: begin
            op_a = {1'b0, r_q};
            op_b = {1'b0, nsh_q};
         end
         default: ;
      endcase
      hi_w = prod[2*W-1:W];
      sh   = (KW+1)'(2 * W - 2) - {1'b0, k_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dn_q    <= '0;
         nsh_q   <= '0;
         r_q     <= '0;
         t_q     <= '0;
         k_q     <= '0;
         it_q    <= '0;
         quo_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (start) begin
               dn_q    <= den_ext << lz;
               nsh_q   <= W'(num) << IN_W;
               k_q     <= lz;
               r_q     <= SEED;
               it_q    <= '0;
               state_q <= ST_EST;
            end
            ST_EST: begin
               t_q     <= hi_w;
               state_q <= ST_REF;
            end
            ST_REF: begin
               r_q <= r_q + hi_w;
               if (it_q == IW'(ITERS - 1)) begin
                  state_q <= ST_SCL;
               end else begin
                  it_q    <= it_q + 1'b1;
                  state_q <= ST_EST;
               end
            end
            ST_SCL: begin
               quo_q   <= W'(prod >> sh);
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state_q != ST_IDLE);
   assign done = done_q;
   assign quo  = quo_q;

   // ---------------- assertions ----------------
   logic [CW-1:0] lat_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             lat_cnt <= '0;
      else if (start && !busy) lat_cnt <= '0;
      else if (busy)           lat_cnt <= lat_cnt + 1'b1;
   end

   a_r1_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_cnt == CW'(LAT)));

   a_r3_normalized: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> dn_q[W-1]);

   a_r4_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r5_restart_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(dn_q) && $stable(nsh_q) && $stable(k_q)));

   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_quo_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(quo) |-> done);
endmodule

// File: tb/tb_nr_recip_div.sv
`timescale 1ns/1ps
module tb_nr_recip_div;
   localparam int LAT = 9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] num = '0;
   logic [15:0] den = '0;
   logic        busy, done;
   logic [31:0] quo;

   int n_chk = 0;
   int n_bad = 0;
   bit ended = 0;

   always #4 clk = ~clk;

   nr_recip_div dut (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .num   (num),
      .den   (den),
      .busy  (busy),
      .done  (done),
      .quo   (quo)
   );

   // {num, den}, each pair with den != 0 and num < 2*den
   localparam logic [31:0] VEC [16] = '{
      {16'h0001, 16'h0001}, {16'h0000, 16'h0005}, {16'h0003, 16'h0002},
      {16'hFFFF, 16'hFFFF}, {16'hFFFF, 16'h9C40}, {16'h0001, 16'h8000},
      {16'h7FFF, 16'h4000}, {16'h0005, 16'h0003}, {16'h3039, 16'h270F},
      {16'h00FF, 16'h0080}, {16'h0001, 16'h0002}, {16'hFFFF, 16'h8000},
      {16'h0007, 16'h0004}, {16'h03E8, 16'h03E7}, {16'h0001, 16'hFFFF},
      {16'h1234, 16'h0ABC}
   };

   function automatic longint expect_q(input logic [15:0] n, input logic [15:0] d);
      return (longint'(n) << 16) / longint'(d);
   endfunction

   function automatic bit in_win(input logic [31:0] q, input longint e);
      return (longint'(q) + 3 >= e) && (longint'(q) <= e + 1);
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic launch(input logic [15:0] n, input logic [15:0] d);
      @(negedge clk);
      num = n; den = d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // run one division, checking R1/R4/R6 timing and R2 value
   task automatic run_op(input logic [15:0] n, input logic [15:0] d, input string req);
      int  c_done;
      bit  seq_ok;
      longint e;
      c_done = 0; seq_ok = 1;
      launch(n, d);
      for (int c = 1; c <= LAT + 2; c++) begin
         @(negedge clk);
         if (done) begin
            if (c_done == 0) c_done = c;
            else seq_ok = 0;
         end
         if (c < LAT && !busy) seq_ok = 0;
         if (c >= LAT && busy) seq_ok = 0;
      end
      check(c_done == LAT && seq_ok, "R1/R4/R6", c_done, LAT);
      e = expect_q(n, d);
      check(in_win(quo, e), req, quo, e);
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] q_keep;
      longint      e;
      int          seen;

      // R8: reset state
      #1;
      check(busy == 0 && done == 0 && quo == 0, "R8 reset", {busy, done, quo != 0}, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 0 && done == 0 && quo == 0, "R8 after release", quo, 0);

      // R2: vector table
      for (int i = 0; i < 16; i++) begin
         run_op(VEC[i][31:16], VEC[i][15:0], "R2");
      end

      // R3: every leading-zero position of the divisor
      for (int k = 0; k < 16; k++) begin
         logic [15:0] d;
         d = 16'(1) << k;
         run_op((k == 0) ? 16'd1 : (d + (d >> 1)), d, "R3");
      end

      // R5: start while busy is ignored
      launch(16'd3, 16'd2);
      seen = 0;
      for (int c = 1; c <= LAT + 12; c++) begin
         if (c == 3) begin
            num = 16'd1; den = 16'hFFFF; start = 1'b1;
         end
         @(negedge clk);
         start = 1'b0;
         if (done) seen = (seen == 0) ? c : -1;
      end
      e = expect_q(16'd3, 16'd2);
      check(seen == LAT, "R5 timing", seen, LAT);
      check(in_win(quo, e), "R5 operands kept", quo, e);

      // R7: quotient holds during the next division
      q_keep = quo;
      launch(16'd1, 16'd3);
      seen = 1;
      for (int c = 1; c < LAT; c++) begin
         @(negedge clk);
         if (quo != q_keep) seen = 0;
      end
      check(seen == 1, "R7 hold", quo, q_keep);
      @(negedge clk);
      e = expect_q(16'd1, 16'd3);
      check(done && in_win(quo, e), "R7 update", quo, e);

      // R8: reset during a division
      launch(16'd5, 16'd4);
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(busy == 0 && done == 0 && quo == 0, "R8 mid-op reset", quo, 0);
      rst_n = 1'b1;
      seen = 0;
      for (int c = 0; c < LAT + 4; c++) begin
         @(negedge clk);
         if (done || busy) seen = 1;
      end
      check(seen == 0, "R8 no done after abort", seen, 0);

      finish_run();
   end
endmodule